// File: doc/BRIEF.md
# Memory-Side Issue Arbiter

This block decides, every cycle, which pending request a cache controller sends to the next memory level. Three sources compete. The first is a queue of outstanding miss entries. The second is a queue of dirty-block write-backs. The third is a prefetch requester that only asks through a valid/ready pair.

Each queue entry arrives on the ports as a valid bit, a byte address and an allocation order number. The allocation logic outside this block gives out order numbers in increasing sequence. The arbiter keeps one in-service flag per entry. A granted entry stays in service, and is no longer a candidate, until its release input is pulsed.

The choice is made combinationally from the current entry state. It is presented as a source code and an entry index. It takes effect on the clock edge where `issueValid` and `issueReady` are both high.

The normal rule gives misses priority over write-backs. Two cases change that rule. A full write-back queue with nothing in service turns the priority toward writes. An address overlap between the two queues forces the older or dirty copy out first.

Top module: `mem_issue_arbiter`

## Requirements
- R1: An entry is a candidate when its valid bit is 1 and its in-service flag is 0. When only the miss queue has a candidate, the source is miss (code 1).
- R2: Within a queue, the candidate with the oldest order number is the one chosen as that queue's head.
- R3: When only the write-back queue has a candidate, the source is write-back (code 2), and the index is that queue's head.
- R4: When both queues have a candidate, and the write-back queue is either not full or has an entry in service, the miss head is chosen unless R6 applies.
- R5: When both queues have a candidate, every write-back entry is valid, and none of them is in service, the write-back head is chosen. The exception is a candidate miss that overlaps it and is older: then the oldest such miss is chosen.
- R6: In the case of R4, if a write-back candidate overlaps the miss head, the oldest such write-back is chosen.
- R7: When neither queue has a candidate, `pfValid` is 1, and at least one miss entry is invalid, the source is prefetch (code 3) and `pfReady` equals `issueReady`. Otherwise the source is none (code 0), `issueValid` is 0, and `pfReady` is 0.
- R8: A granted miss or write-back entry is marked in service on the grant edge. It stays in service until a release pulse for that entry clears the flag on the next edge. Reset clears all in-service flags.
- R9: While `issueReady` is 0, no in-service flag changes except through a release pulse.
- R10: Order numbers are compared modulo 2^ORD_W. Order a is older than order b when (a - b) mod 2^ORD_W has its top bit set.
- R11: Two entries overlap when their addresses are equal after the low log2(BLK_BYTES) bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | MQ | Miss entry valid bits |
| missAddr | input | MQ*ADDR_W | Miss entry byte addresses, entry i at bits i*ADDR_W |
| missOrder | input | MQ*ORD_W | Miss entry order numbers |
| missRelease | input | MQ | Clears a miss entry's in-service flag |
| wbValid | input | WQ | Write-back entry valid bits |
| wbAddr | input | WQ*ADDR_W | Write-back entry byte addresses |
| wbOrder | input | WQ*ORD_W | Write-back entry order numbers |
| wbRelease | input | WQ | Clears a write-back entry's in-service flag |
| pfValid | input | 1 | Prefetch request pending |
| pfReady | output | 1 | Prefetch request accepted this cycle |
| issueReady | input | 1 | Memory side accepts the selection |
| issueValid | output | 1 | A selection is presented |
| issueSrc | output | 2 | 0 none, 1 miss, 2 write-back, 3 prefetch |
| issueIdx | output | IDX_W | Entry index in the selected queue |

## Verification
All selection outputs are combinational. They are therefore due in the same cycle as the entry state that produced them. The bench drives inputs just after a rising edge and compares at the following falling edge.

In-service flags change on the edge after a grant or release. The reference model takes its next flag values on that same edge. The first cycle that can show the effect is the next compare point, one cycle after the stimulus.

// File: rtl/mem_issue_arbiter_pkg.sv
package mem_issue_arbiter_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MISS = 2'd1,
    SRC_WB   = 2'd2,
    SRC_PF   = 2'd3
  } issueSrc_e;

  // control -> datapath
  typedef struct packed {
    logic grantMiss;
    logic grantWb;
  } arbStb_t;

  // datapath -> control
  typedef struct packed {
    logic missHeadHit;
    logic wbHeadHit;
    logic missConfHit;
    logic wbConfHit;
    logic missFull;
    logic wbFull;
    logic wbIdle;
  } arbFlags_t;

endpackage

// File: rtl/mem_issue_arbiter_dp.sv
module mem_issue_arbiter_dp
  import mem_issue_arbiter_pkg::*;
#(
  parameter int MQ        = 4,
  parameter int WQ        = 4,
  parameter int ADDR_W    = 32,
  parameter int ORD_W     = 8,
  parameter int BLK_BYTES = 64,
  parameter int IDX_W     = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MQ-1:0]        missValid,
  input  logic [MQ*ADDR_W-1:0] missAddr,
  input  logic [MQ*ORD_W-1:0]  missOrder,
  input  logic [MQ-1:0]        missRelease,
  input  logic [WQ-1:0]        wbValid,
  input  logic [WQ*ADDR_W-1:0] wbAddr,
  input  logic [WQ*ORD_W-1:0]  wbOrder,
  input  logic [WQ-1:0]        wbRelease,
  input  arbStb_t              ctrlStb,
  input  logic [IDX_W-1:0]     grantIdx,
  output arbFlags_t            dpFlags,
  output logic [IDX_W-1:0]     missHeadIdx,
  output logic [IDX_W-1:0]     wbHeadIdx,
  output logic [IDX_W-1:0]     missConfIdx,
  output logic [IDX_W-1:0]     wbConfIdx
);

  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int BLK_W = ADDR_W - OFF_W;

  logic [BLK_W-1:0] mBlk [MQ];
  logic [ORD_W-1:0] mOrd [MQ];
  logic [BLK_W-1:0] wBlk [WQ];
  logic [ORD_W-1:0] wOrd [WQ];
  logic [MQ-1:0]    missSvc, missCand, missGrantVec;
  logic [WQ-1:0]    wbSvc, wbCand, wbGrantVec;
  logic             missHit, wbHit, mConfHit, wConfHit;

  // wrap-aware age test: a is older than b
  function automatic logic isOlder(input logic [ORD_W-1:0] a, input logic [ORD_W-1:0] b);
    logic [ORD_W-1:0] diff;
    diff = a - b;
    return diff[ORD_W-1];
  endfunction

  for (genvar i = 0; i < MQ; i++) begin : g_missUnpack
    assign mBlk[i] = missAddr[i*ADDR_W+OFF_W +: BLK_W];
    assign mOrd[i] = missOrder[i*ORD_W +: ORD_W];
  end
  for (genvar j = 0; j < WQ; j++) begin : g_wbUnpack
    assign wBlk[j] = wbAddr[j*ADDR_W+OFF_W +: BLK_W];
    assign wOrd[j] = wbOrder[j*ORD_W +: ORD_W];
  end

  assign missGrantVec = ctrlStb.grantMiss ? (MQ'(1) << grantIdx) : '0;
  assign wbGrantVec   = ctrlStb.grantWb   ? (WQ'(1) << grantIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missSvc <= '0;
      wbSvc   <= '0;
    end else begin
      missSvc <= (missSvc | missGrantVec) & ~missRelease;
      wbSvc   <= (wbSvc | wbGrantVec) & ~wbRelease;
    end
  end

  assign missCand = missValid & ~missSvc;
  assign wbCand   = wbValid & ~wbSvc;

  // oldest candidate of each queue
  always_comb begin
    missHit = 1'b0;
    missHeadIdx = '0;
    for (int i = 0; i < MQ; i++) begin
      if (missCand[i] && (!missHit || isOlder(mOrd[i], mOrd[missHeadIdx]))) begin
        missHit = 1'b1;
        missHeadIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    wbHit = 1'b0;
    wbHeadIdx = '0;
    for (int j = 0; j < WQ; j++) begin
      if (wbCand[j] && (!wbHit || isOlder(wOrd[j], wOrd[wbHeadIdx]))) begin
        wbHit = 1'b1;
        wbHeadIdx = IDX_W'(j);
      end
    end
  end

  // older miss overlapping the write-back head
  always_comb begin
    mConfHit = 1'b0;
    missConfIdx = '0;
    for (int i = 0; i < MQ; i++) begin
      if (missCand[i] && mBlk[i] == wBlk[wbHeadIdx] && isOlder(mOrd[i], wOrd[wbHeadIdx])
          && (!mConfHit || isOlder(mOrd[i], mOrd[missConfIdx]))) begin
        mConfHit = 1'b1;
        missConfIdx = IDX_W'(i);
      end
    end
  end

  // write-back overlapping the miss head
  always_comb begin
    wConfHit = 1'b0;
    wbConfIdx = '0;
    for (int j = 0; j < WQ; j++) begin
      if (wbCand[j] && wBlk[j] == mBlk[missHeadIdx]
          && (!wConfHit || isOlder(wOrd[j], wOrd[wbConfIdx]))) begin
        wConfHit = 1'b1;
        wbConfIdx = IDX_W'(j);
      end
    end
  end

  assign dpFlags.missHeadHit = missHit;
  assign dpFlags.wbHeadHit   = wbHit;
  assign dpFlags.missConfHit = mConfHit && wbHit;
  assign dpFlags.wbConfHit   = wConfHit && missHit;
  assign dpFlags.missFull    = &missValid;
  assign dpFlags.wbFull      = &wbValid;
  assign dpFlags.wbIdle      = ~|(wbValid & wbSvc);

endmodule

// File: rtl/mem_issue_arbiter_ctrl.sv
module mem_issue_arbiter_ctrl
  import mem_issue_arbiter_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  arbFlags_t        dpFlags,
  input  logic [IDX_W-1:0] missHeadIdx,
  input  logic [IDX_W-1:0] wbHeadIdx,
  input  logic [IDX_W-1:0] missConfIdx,
  input  logic [IDX_W-1:0] wbConfIdx,
  input  logic             pfValid,
  input  logic             issueReady,
  output logic             issueValid,
  output issueSrc_e        issueSrc,
  output logic [IDX_W-1:0] issueIdx,
  output logic             pfReady,
  output arbStb_t          ctrlStb
);

  always_comb begin
    issueSrc = SRC_NONE;
    issueIdx = '0;
    if (dpFlags.missHeadHit && dpFlags.wbHeadHit) begin
      if (dpFlags.wbFull && dpFlags.wbIdle) begin
        if (dpFlags.missConfHit) begin
          issueSrc = SRC_MISS;
          issueIdx = missConfIdx;
        end else begin
          issueSrc = SRC_WB;
          issueIdx = wbHeadIdx;
        end
      end else if (dpFlags.wbConfHit) begin
        issueSrc = SRC_WB;
        issueIdx = wbConfIdx;
      end else begin
        issueSrc = SRC_MISS;
        issueIdx = missHeadIdx;
      end
    end else if (dpFlags.missHeadHit) begin
      issueSrc = SRC_MISS;
      issueIdx = missHeadIdx;
    end else if (dpFlags.wbHeadHit) begin
      issueSrc = SRC_WB;
      issueIdx = wbHeadIdx;
    end else if (pfValid && !dpFlags.missFull) begin
      issueSrc = SRC_PF;
    end
  end

  assign issueValid        = (issueSrc != SRC_NONE);
  assign pfReady           = issueReady && (issueSrc == SRC_PF);
  assign ctrlStb.grantMiss = issueReady && (issueSrc == SRC_MISS);
  assign ctrlStb.grantWb   = issueReady && (issueSrc == SRC_WB);

endmodule

// File: rtl/mem_issue_arbiter.sv
module mem_issue_arbiter
  import mem_issue_arbiter_pkg::*;
#(
  parameter int MQ        = 4,
  parameter int WQ        = 4,
  parameter int ADDR_W    = 32,
  parameter int ORD_W     = 8,
  parameter int BLK_BYTES = 64,
  localparam int MAXQ     = (MQ > WQ) ? MQ : WQ,
  localparam int IDX_W    = (MAXQ > 1) ? $clog2(MAXQ) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MQ-1:0]        missValid,
  input  logic [MQ*ADDR_W-1:0] missAddr,
  input  logic [MQ*ORD_W-1:0]  missOrder,
  input  logic [MQ-1:0]        missRelease,
  input  logic [WQ-1:0]        wbValid,
  input  logic [WQ*ADDR_W-1:0] wbAddr,
  input  logic [WQ*ORD_W-1:0]  wbOrder,
  input  logic [WQ-1:0]        wbRelease,
  input  logic                 pfValid,
  output logic                 pfReady,
  input  logic                 issueReady,
  output logic                 issueValid,
  output logic [1:0]           issueSrc,
  output logic [IDX_W-1:0]     issueIdx
);

  arbStb_t          ctrlStb;
  arbFlags_t        dpFlags;
  issueSrc_e        srcSel;
  logic [IDX_W-1:0] missHeadIdx, wbHeadIdx, missConfIdx, wbConfIdx;

  mem_issue_arbiter_dp #(
    .MQ(MQ), .WQ(WQ), .ADDR_W(ADDR_W), .ORD_W(ORD_W),
    .BLK_BYTES(BLK_BYTES), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missAddr(missAddr), .missOrder(missOrder),
    .missRelease(missRelease),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbOrder(wbOrder),
    .wbRelease(wbRelease),
    .ctrlStb(ctrlStb), .grantIdx(issueIdx), .dpFlags(dpFlags),
    .missHeadIdx(missHeadIdx), .wbHeadIdx(wbHeadIdx),
    .missConfIdx(missConfIdx), .wbConfIdx(wbConfIdx)
  );

  mem_issue_arbiter_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .dpFlags(dpFlags),
    .missHeadIdx(missHeadIdx), .wbHeadIdx(wbHeadIdx),
    .missConfIdx(missConfIdx), .wbConfIdx(wbConfIdx),
    .pfValid(pfValid), .issueReady(issueReady),
    .issueValid(issueValid), .issueSrc(srcSel), .issueIdx(issueIdx),
    .pfReady(pfReady), .ctrlStb(ctrlStb)
  );

  assign issueSrc = srcSel;

endmodule

// File: rtl/mem_issue_arbiter_chk.sv
module mem_issue_arbiter_chk #(
  parameter int MQ    = 4,
  parameter int WQ    = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [MQ-1:0]    missValid,
  input logic [MQ-1:0]    missRelease,
  input logic [WQ-1:0]    wbValid,
  input logic [WQ-1:0]    wbRelease,
  input logic             pfValid,
  input logic             issueReady,
  input logic             issueValid,
  input logic [1:0]       issueSrc,
  input logic [IDX_W-1:0] issueIdx
);

  assert_miss_entry_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueSrc == 2'd1) |-> missValid[issueIdx]);

  assert_wb_entry_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueSrc == 2'd2) |-> wbValid[issueIdx]);

  assert_pf_room_R7: assert property (@(posedge clk) disable iff (!rstN)
    (issueSrc == 2'd3) |-> (pfValid && !(&missValid)));

  assert_miss_no_regrant_R8: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && issueSrc == 2'd1 && !missRelease[issueIdx])
    |=> !(issueValid && issueSrc == 2'd1 && issueIdx == $past(issueIdx)));

  assert_wb_no_regrant_R8: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady && issueSrc == 2'd2 && !wbRelease[issueIdx])
    |=> !(issueValid && issueSrc == 2'd2 && issueIdx == $past(issueIdx)));

endmodule

bind mem_issue_arbiter mem_issue_arbiter_chk #(.MQ(MQ), .WQ(WQ), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .missValid(missValid), .missRelease(missRelease),
  .wbValid(wbValid), .wbRelease(wbRelease), .pfValid(pfValid),
  .issueReady(issueReady), .issueValid(issueValid), .issueSrc(issueSrc),
  .issueIdx(issueIdx)
);

// File: tb/mem_issue_arbiter_tb.sv
`timescale 1ns/1ps
module mem_issue_arbiter_tb;
  localparam int MQ = 4, WQ = 4, AW = 32, OW = 8, IW = 2;

  logic clk = 0, rstN = 0;
  logic [MQ-1:0] missValid = '0, missRelease = '0;
  logic [MQ*AW-1:0] missAddr = '0;
  logic [MQ*OW-1:0] missOrder = '0;
  logic [WQ-1:0] wbValid = '0, wbRelease = '0;
  logic [WQ*AW-1:0] wbAddr = '0;
  logic [WQ*OW-1:0] wbOrder = '0;
  logic pfValid = 0, issueReady = 0;
  logic pfReady, issueValid;
  logic [1:0] issueSrc;
  logic [IW-1:0] issueIdx;

  logic [MQ-1:0] ms = '0;  // model in-service flags
  logic [WQ-1:0] ws = '0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mem_issue_arbiter u_dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .missOrder(missOrder), .missRelease(missRelease), .wbValid(wbValid),
    .wbAddr(wbAddr), .wbOrder(wbOrder), .wbRelease(wbRelease),
    .pfValid(pfValid), .pfReady(pfReady), .issueReady(issueReady),
    .issueValid(issueValid), .issueSrc(issueSrc), .issueIdx(issueIdx)
  );

  function automatic bit older(int a, int b);
    return (((a - b) & 255) >= 128);
  endfunction
  function automatic int mBlkOf(int i); return int'(missAddr[i*AW +: AW]) >>> 6; endfunction
  function automatic int wBlkOf(int i); return int'(wbAddr[i*AW +: AW]) >>> 6; endfunction
  function automatic int mOrdOf(int i); return int'(missOrder[i*OW +: OW]); endfunction
  function automatic int wOrdOf(int i); return int'(wbOrder[i*OW +: OW]); endfunction

  task automatic setMiss(int i, bit v, int a, int o);
    missValid[i] = v; missAddr[i*AW +: AW] = a; missOrder[i*OW +: OW] = OW'(o);
  endtask
  task automatic setWb(int i, bit v, int a, int o);
    wbValid[i] = v; wbAddr[i*AW +: AW] = a; wbOrder[i*OW +: OW] = OW'(o);
  endtask

  task automatic expected(output int src, output int idx);
    int mh = -1, wh = -1, mc = -1, wc = -1;
    for (int i = 0; i < MQ; i++)
      if (missValid[i] && !ms[i] && (mh < 0 || older(mOrdOf(i), mOrdOf(mh)))) mh = i;
    for (int j = 0; j < WQ; j++)
      if (wbValid[j] && !ws[j] && (wh < 0 || older(wOrdOf(j), wOrdOf(wh)))) wh = j;
    src = 0; idx = 0;
    if (mh >= 0 && wh >= 0) begin
      if (wbValid == '1 && (wbValid & ws) == '0) begin
        for (int i = 0; i < MQ; i++)
          if (missValid[i] && !ms[i] && mBlkOf(i) == wBlkOf(wh) && older(mOrdOf(i), wOrdOf(wh))
              && (mc < 0 || older(mOrdOf(i), mOrdOf(mc)))) mc = i;
        if (mc >= 0) begin src = 1; idx = mc; end else begin src = 2; idx = wh; end
      end else begin
        for (int j = 0; j < WQ; j++)
          if (wbValid[j] && !ws[j] && wBlkOf(j) == mBlkOf(mh)
              && (wc < 0 || older(wOrdOf(j), wOrdOf(wc)))) wc = j;
        if (wc >= 0) begin src = 2; idx = wc; end else begin src = 1; idx = mh; end
      end
    end else if (mh >= 0) begin src = 1; idx = mh; end
    else if (wh >= 0) begin src = 2; idx = wh; end
    else if (pfValid && missValid != '1) src = 3;
  endtask

  // compare at the falling edge, advance the model on the rising edge
  task automatic tick(string tag);
    int eSrc, eIdx;
    logic [MQ-1:0] msN;
    logic [WQ-1:0] wsN;
    @(negedge clk);
    expected(eSrc, eIdx);
    total++;
    if (issueValid !== (eSrc != 0) || issueSrc !== 2'(eSrc) ||
        (eSrc inside {1, 2} && issueIdx !== IW'(eIdx)) ||
        pfReady !== (issueReady && eSrc == 3)) begin
      bad++;
      $display("FAIL %s: got valid=%0b src=%0d idx=%0d pfReady=%0b, expected src=%0d idx=%0d pfReady=%0b",
               tag, issueValid, issueSrc, issueIdx, pfReady, eSrc, eIdx, issueReady && eSrc == 3);
    end
    msN = ms; wsN = ws;
    for (int i = 0; i < MQ; i++) begin
      if (issueReady && eSrc == 1 && eIdx == i) msN[i] = 1;
      if (missRelease[i]) msN[i] = 0;
    end
    for (int j = 0; j < WQ; j++) begin
      if (issueReady && eSrc == 2 && eIdx == j) wsN[j] = 1;
      if (wbRelease[j]) wsN[j] = 0;
    end
    @(posedge clk);
    if (rstN) begin ms = msN; ws = wsN; end
    #0.5;
  endtask

  task automatic clearAll();
    missValid = '0; wbValid = '0; pfValid = 0; issueReady = 0;
    missRelease = '1; wbRelease = '1;
    tick("R8 release all");
    missRelease = '0; wbRelease = '0;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5;
    rstN = 1;
    tick("R8 reset state idle");

    // R1 R2: only misses, oldest first
    setMiss(0, 1, 'h100, 5); setMiss(1, 1, 'h200, 3); setMiss(2, 1, 'h300, 7);
    tick("R2 oldest miss head");
    issueReady = 1;
    tick("R1 grant miss 1");
    tick("R2 next oldest miss 0");
    tick("R8 grant miss 2");
    pfValid = 1;
    tick("R7 prefetch with free miss slot");
    issueReady = 0;
    setMiss(3, 1, 'h400, 9);
    tick("R7 candidate beats prefetch");
    issueReady = 1;
    tick("R1 grant miss 3");
    tick("R7 prefetch blocked when miss queue full");
    issueReady = 0;
    tick("R9 no grant while not ready");
    clearAll();

    // R3 R4 R6 R11
    setWb(0, 1, 'h1000, 20); setWb(1, 1, 'h2000, 18);
    tick("R3 only write-back ready");
    setMiss(0, 1, 'h5000, 30);
    tick("R4 miss favoured when wb not full");
    setWb(2, 1, 'h5010, 31);
    tick("R6 R11 overlapping write-back first");
    clearAll();

    // R5: full write-back queue
    setWb(0, 1, 'h100, 40); setWb(1, 1, 'h200, 41); setWb(2, 1, 'h300, 42); setWb(3, 1, 'h400, 43);
    setMiss(0, 1, 'h9000, 44);
    tick("R5 full wb idle favours write");
    setMiss(1, 1, 'h120, 39);
    tick("R5 older overlapping miss first");
    setMiss(1, 1, 'h120, 45);
    tick("R5 younger overlap does not win");
    issueReady = 1;
    tick("R8 grant wb 0");
    issueReady = 0;
    tick("R5 wb in service restores miss priority");
    tick("R9 state held without ready");
    wbRelease[0] = 1;
    tick("R8 release pulse cycle");
    wbRelease[0] = 0;
    tick("R8 released wb is candidate again");
    clearAll();

    // R10: wrap-aware age
    setMiss(0, 1, 'h100, 250); setMiss(1, 1, 'h200, 2);
    tick("R10 order 250 older than 2");
    issueReady = 1;
    tick("R10 grant wrapped oldest");
    tick("R10 then order 2");
    issueReady = 0;
    clearAll();
    tick("R7 idle without prefetch");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule